// File: doc/BRIEF.md
# Strobe-Addressed Output Port with Synchronised Input Port

This block is a small parallel I/O port for a host register bus. The host never rewrites the whole output word. Instead, it changes chosen output bits through two strobe addresses. Writing a word to the set address turns on every latch bit where the word has a one. Writing a word to the clear address turns off every latch bit where the word has a one. In both cases the other bits keep their values, so two pieces of software can each own different pins without a read-modify-write race.

Each output pin drives the complement of its latch bit, so a set bit pulls the pin low. A per-pin mode register selects whether the pin follows its latch bit or an alternate internal source. The alternate sources are tied off in this block, so a pin in alternate mode rests high.

A group of input pins, typically modem-status lines, passes through a two-flop synchroniser. The host reads the result at the same address that carries the mode register on writes. The reported levels are raw, so an asserted (driven-low) line reads as 0.

Top module: `outport_strobe`

## Requirements
- R1: After reset the output latch and the mode register are all zeros, so every output pin is high.
- R2: A write (bus_wr=1) to address 0xE sets every latch bit whose data bit is 1 and leaves the other latch bits unchanged.
- R3: A write to address 0xF clears every latch bit whose data bit is 1 and leaves the other latch bits unchanged.
- R4: A write to any other address, or bus_wr=0 at any address, leaves the output latch unchanged.
- R5: With its mode bit 0, output pin i equals the inverse of latch bit i, so it is low exactly when the bit is set.
- R6: A write to address 0xD loads the mode register. With mode bit i = 1, pin i is high whatever latch bit i holds. The latch keeps its value, and it shows again on the pin once mode bit i returns to 0.
- R7: With bus_addr = 0xD, rd_data bits [IN_W-1:0] show the synchronised input pin levels unmodified (a low pin reads 0) and the upper bits read 0. At any other address rd_data is all zeros.
- R8: A change on an input pin is not visible in rd_data after one rising clock edge, and is visible after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational on bus_addr |
| in_pins | input | 7 | Asynchronous input pins |
| out_pins | output | 8 | Output pins, active low relative to the latch |

## Verification
The checks assume that each write lasts one cycle with a single address, so a set and a clear can never coincide. The bench drives exactly one address per write, on the falling edge. The input-latency property also assumes the input pins are quiet and high during reset, as they are in the bench. All input changes are made away from the clock edge, so the two-edge latency is exact and deterministic.

// File: rtl/ops_pkg.sv
package ops_pkg;
   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_SET  = 2'd1,
      ACC_CLR  = 2'd2,
      ACC_MODE = 2'd3
   } ops_acc_e;
endpackage

// File: rtl/ops_decode.sv
module ops_decode
   import ops_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int SET_ADDR = 14,
   parameter int CLR_ADDR = 15,
   parameter int IO_ADDR  = 13
) (
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   output ops_acc_e          acc
);
   always_comb begin
      acc = ACC_NONE;
      if (wr) begin
         if (addr == ADDR_W'(SET_ADDR))      acc = ACC_SET;
         else if (addr == ADDR_W'(CLR_ADDR)) acc = ACC_CLR;
         else if (addr == ADDR_W'(IO_ADDR))  acc = ACC_MODE;
      end
   end
endmodule

// File: rtl/ops_latch.sv
module ops_latch #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_stb,
   input  logic         clr_stb,
   input  logic [W-1:0] mask,
   output logic [W-1:0] q
);
   logic [W-1:0] set_m, clr_m;
   assign set_m = set_stb ? mask : '0;
   assign clr_m = clr_stb ? mask : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= (q | set_m) & ~clr_m;
   end
endmodule

// File: rtl/ops_sync.sv
module ops_sync #(
   parameter int W      = 7,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '1;
      else        chain[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '1;
         else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/outport_strobe.sv
module outport_strobe
   import ops_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int IN_W        = 7,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2,
   parameter int SET_ADDR    = 14,
   parameter int CLR_ADDR    = 15,
   parameter int IO_ADDR     = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] rd_data,
   input  logic [IN_W-1:0]   in_pins,
   output logic [DATA_W-1:0] out_pins
);
   localparam int PAD_W = DATA_W - IN_W;

   if (IN_W > DATA_W)       begin : g_bad_w   $error("IN_W exceeds DATA_W"); end
   if (SYNC_STAGES < 2)     begin : g_bad_s   $error("SYNC_STAGES below 2"); end
   if (SET_ADDR == CLR_ADDR || SET_ADDR == IO_ADDR || CLR_ADDR == IO_ADDR)
                            begin : g_bad_a   $error("address clash"); end

   ops_acc_e          acc;
   logic [DATA_W-1:0] latch_q;
   logic [DATA_W-1:0] mode_q;
   logic [IN_W-1:0]   in_sync;
   logic [IN_W-1:0]   in_view;

   ops_decode #(
      .ADDR_W(ADDR_W), .SET_ADDR(SET_ADDR), .CLR_ADDR(CLR_ADDR), .IO_ADDR(IO_ADDR)
   ) i_dec (
      .wr(bus_wr), .addr(bus_addr), .acc(acc)
   );

   ops_latch #(.W(DATA_W)) i_latch (
      .clk(clk), .rst_n(rst_n),
      .set_stb(acc == ACC_SET), .clr_stb(acc == ACC_CLR),
      .mask(bus_wdata), .q(latch_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                mode_q <= '0;
      else if (acc == ACC_MODE)  mode_q <= bus_wdata;
   end

   ops_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .d(in_pins), .q(in_sync)
   );

   for (genvar i = 0; i < DATA_W; i++) begin : g_pin
      assign out_pins[i] = mode_q[i] ? 1'b1 : ~latch_q[i];
   end

   assign in_view = (bus_addr == ADDR_W'(IO_ADDR)) ? in_sync : '0;

   if (PAD_W > 0) begin : g_pad
      assign rd_data = {{PAD_W{1'b0}}, in_view};
   end else begin : g_nopad
      assign rd_data = in_view;
   end
endmodule

// File: rtl/outport_strobe_check.sv
module outport_strobe_check #(
   parameter int DATA_W   = 8,
   parameter int IN_W     = 7,
   parameter int ADDR_W   = 4,
   parameter int SET_ADDR = 14,
   parameter int CLR_ADDR = 15,
   parameter int IO_ADDR  = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] rd_data,
   input logic [IN_W-1:0]   in_pins,
   input logic [DATA_W-1:0] out_pins,
   input logic [DATA_W-1:0] latch
);
   logic [1:0] warm;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         warm <= '0;
      else if (warm != 3) warm <= warm + 2'd1;
   end

   AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (warm == 0) |-> (out_pins == '1)); // R1

   AST_SET_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(SET_ADDR))
      |=> ((latch & $past(bus_wdata)) == $past(bus_wdata))); // R2

   AST_CLR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(CLR_ADDR))
      |=> ((latch & $past(bus_wdata)) == '0)); // R3

   AST_HOLD_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_wr || (bus_addr != ADDR_W'(SET_ADDR) && bus_addr != ADDR_W'(CLR_ADDR)))
      |=> $stable(latch)); // R4

   AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      (warm >= 2 && bus_addr == ADDR_W'(IO_ADDR))
      |-> (rd_data[IN_W-1:0] == $past(in_pins, 2))); // R8

   AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr != ADDR_W'(IO_ADDR)) |-> (rd_data == '0)); // R7
endmodule

bind outport_strobe outport_strobe_check #(
   .DATA_W(DATA_W), .IN_W(IN_W), .ADDR_W(ADDR_W),
   .SET_ADDR(SET_ADDR), .CLR_ADDR(CLR_ADDR), .IO_ADDR(IO_ADDR)
) i_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .rd_data(rd_data), .in_pins(in_pins),
   .out_pins(out_pins), .latch(latch_q)
);

// File: tb/test_outport_strobe.sv
module test_outport_strobe;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic [3:0] bus_addr = 4'h0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] rd_data;
   logic [6:0] in_pins = 7'h7F;
   logic [7:0] out_pins;

   int n_chk = 0;
   int n_bad = 0;
   logic [7:0] exp_latch = 8'h00;
   logic [7:0] exp_mode = 8'h00;

   always #10 clk = ~clk;

   outport_strobe i_outport_strobe (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .rd_data(rd_data), .in_pins(in_pins),
      .out_pins(out_pins)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic en);
      @(negedge clk);
      bus_wr = en; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = 4'h0; bus_wdata = 8'h00;
      if (en && a == 4'hE) exp_latch = exp_latch | d;
      if (en && a == 4'hF) exp_latch = exp_latch & ~d;
      if (en && a == 4'hD) exp_mode = d;
   endtask

   function automatic logic [7:0] pins_exp();
      return exp_mode | ~exp_latch;
   endfunction

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 pins idle", out_pins, 8'hFF);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 pins after release", out_pins, 8'hFF);

      // R2/R5 sweep: set each value from empty latch
      for (int v = 0; v < 256; v++) begin
         wr(4'hF, 8'hFF, 1'b1);
         wr(4'hE, 8'(v), 1'b1);
         chk("R2 R5 set sweep", out_pins, pins_exp());
      end
      // R2 accumulation leaves other bits
      wr(4'hF, 8'hFF, 1'b1);
      wr(4'hE, 8'h81, 1'b1);
      wr(4'hE, 8'h18, 1'b1);
      chk("R2 set keeps others", out_pins, 8'h66);

      // R3 sweep: clear each mask from a full latch
      for (int v = 0; v < 256; v++) begin
         wr(4'hE, 8'hFF, 1'b1);
         wr(4'hF, 8'(v), 1'b1);
         chk("R3 clear sweep", out_pins, pins_exp());
      end

      // R4: other addresses and no strobe
      wr(4'hF, 8'hFF, 1'b1);
      wr(4'hE, 8'hA5, 1'b1);
      for (int a = 0; a < 16; a++) begin
         if (a != 13 && a != 14 && a != 15) begin
            wr(4'(a), 8'hFF, 1'b1);
            chk("R4 other address", out_pins, 8'h5A);
         end
      end
      wr(4'hE, 8'hFF, 1'b0);
      chk("R4 set without strobe", out_pins, 8'h5A);
      wr(4'hF, 8'hFF, 1'b0);
      chk("R4 clear without strobe", out_pins, 8'h5A);

      // R6: mode register masks pins, latch kept
      wr(4'hE, 8'hFF, 1'b1);
      wr(4'hD, 8'hF0, 1'b1);
      chk("R6 alt mode high", out_pins, 8'hF0);
      wr(4'hF, 8'h30, 1'b1);
      chk("R6 latch still writable", out_pins, pins_exp());
      wr(4'hD, 8'h00, 1'b0);
      chk("R6 mode write without strobe", out_pins, pins_exp());
      wr(4'hD, 8'h00, 1'b1);
      chk("R6 latch restored", out_pins, 8'h30);

      // R7/R8: input sweep with latency
      @(negedge clk);
      bus_addr = 4'hD;
      for (int v = 0; v < 128; v++) begin
         logic [6:0] prev;
         prev = in_pins;
         in_pins = 7'(v ^ 7'h55);
         @(negedge clk);
         chk("R8 not yet visible", rd_data, {1'b0, prev});
         @(negedge clk);
         chk("R7 R8 visible after two", rd_data, {1'b0, 7'(v ^ 7'h55)});
      end
      in_pins = 7'h00;
      repeat (3) @(negedge clk);
      chk("R7 all asserted read zero", rd_data, 8'h00);
      in_pins = 7'h7F;
      repeat (3) @(negedge clk);
      chk("R7 top bit zero", rd_data, 8'h7F);
      bus_addr = 4'hE;
      #1;
      chk("R7 other address reads zero", rd_data, 8'h00);
      bus_addr = 4'h0;

      // R1: reset mid-run
      wr(4'hE, 8'hFF, 1'b1);
      wr(4'hD, 8'h0F, 1'b1);
      @(negedge clk);
      rst_n = 1'b0;
      exp_latch = 8'h00; exp_mode = 8'h00;
      @(negedge clk);
      chk("R1 reset clears", out_pins, 8'hFF);
      rst_n = 1'b1;
      wr(4'hE, 8'h01, 1'b1);
      chk("R1 mode cleared by reset", out_pins, 8'hFE);

      finish_run();
   end
endmodule